// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers three interrupt events for a small 8-bit core: a timer overflow strobe, a change on an 8-bit input port, and an external interrupt pin. Each event latches a sticky flag bit. A mask register chooses which flags may raise the request. A global enable, turned on by an enable-interrupts command and off by a disable-interrupts command, gates the single interrupt request output.

Software sees the flags only through the mask: a flag read returns the flag bits ANDed with the mask bits. A write to the flag register can clear bits but can never set them. Writing a 0 to a bit position clears that flag, and writing a 1 leaves it unchanged. The port watcher compares the pins against a reference latch. The latch is loaded when software reads the port, so software must read the port before it enables the port-change interrupt.

The timer, the pins and the vectoring logic are outside the block. They arrive as plain synchronous inputs.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag readback, the mask readback and `irq_o` are all 0, and the global enable is off.
- R2: The timer strobe `tmr_n_i` is active low. A 1-to-0 transition seen between two clock edges sets flag bit 0 at that edge. A steady level or a rising transition sets nothing.
- R3: A 1-to-0 transition on the external pin `ext_n_i` sets flag bit 2 at that edge. A steady level or a rising transition sets nothing.
- R4: Flag bit 1 is set at every edge where `port_i` differs from the reference latch. The latch resets to 0 and is loaded with `port_i` at each edge where `port_rd_i` is 1.
- R5: A flag write with `flag_wr_i`=1 clears each flag whose bit in `wdata_i` is 0. A bit written as 1 keeps its old value. A write never sets a flag.
- R6: When a hardware set and a software clear hit the same flag at the same edge, the flag ends up set.
- R7: `flag_rd_o` equals the flag bits ANDed with the mask bits. Bits 7 to 3 are always 0.
- R8: A mask write with `mask_wr_i`=1 loads `wdata_i` bits 2 to 0. Bit 0 enables the timer interrupt, bit 1 the port-change interrupt and bit 2 the external interrupt. `mask_rd_o` bits 7 to 3 read 0.
- R9: `irq_o` is 1 exactly when the global enable is on and at least one flag is set with its mask bit set.
- R10: `eni_i` turns the global enable on at the next edge and `disi_i` turns it off. If both are 1 at the same edge, the enable ends up off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_n_i | input | 1 | Timer overflow strobe, active low |
| ext_n_i | input | 1 | External interrupt pin, active low |
| port_i | input | 8 | Port pin levels |
| port_rd_i | input | 1 | Port read; loads the reference latch |
| flag_wr_i | input | 1 | Flag register write strobe |
| mask_wr_i | input | 1 | Mask register write strobe |
| wdata_i | input | 8 | Write data for flag and mask writes |
| eni_i | input | 1 | Enable-interrupts command |
| disi_i | input | 1 | Disable-interrupts command |
| flag_rd_o | output | 8 | Flag bits ANDed with mask bits |
| mask_rd_o | output | 8 | Mask readback |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume every input is synchronous to `clk` and changes only between edges. They also assume the pins are idle high when reset is released, so the first edge after reset sees no false fall. The stimulus keeps to these rules: the bench drives everything on the falling clock edge, holds the pins high and the port at 0 through reset, and then changes the port only now and then. This leaves room for cycles in which a port read clears the mismatch. Directed cases cover a set and a clear at the same edge, and enable and disable commands at the same edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 3;
  localparam int BIT_TMR = 0;
  localparam int BIT_PCH = 1;
  localparam int BIT_EXT = 2;

  // new flag value after an optional software write and a hardware set
  function automatic logic [NSRC-1:0] flag_next(input logic [NSRC-1:0] cur,
                                                input logic wr,
                                                input logic [NSRC-1:0] wdata,
                                                input logic [NSRC-1:0] set);
    logic [NSRC-1:0] kept;
    kept = wr ? (cur & wdata) : cur;
    return kept | set;
  endfunction

  function automatic logic [NSRC-1:0] masked(input logic [NSRC-1:0] f,
                                             input logic [NSRC-1:0] m);
    return f & m;
  endfunction
endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_det
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= pin_i[i];
    end
    assign fall_o[i] = prev_q & ~pin_i[i];

    // R2
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic         load_i,
  output logic         change_o
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (load_i) ref_q <= pins_i;
  end

  assign change_o = |(ref_q ^ pins_i);

  // R4
  load_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!change_o || (pins_i != $past(pins_i))));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_next(flag_q, wr_en_i, wr_data_i, set_i);
  end

  assign flag_o = flag_q;

  // R5
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_n_i,
  input  logic              ext_n_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              port_rd_i,
  input  logic              flag_wr_i,
  input  logic              mask_wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              eni_i,
  input  logic              disi_i,
  output logic [REG_W-1:0]  flag_rd_o,
  output logic [REG_W-1:0]  mask_rd_o,
  output logic              irq_o
);
  localparam int PAD = REG_W - NSRC;

  logic [1:0]      pin_fall;
  logic            port_chg;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] live;
  logic            gie_q;

  irq_fall_det #(.N(2)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({ext_n_i, tmr_n_i}),
    .fall_o (pin_fall)
  );

  irq_port_watch #(.W(PORT_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_i   (port_i),
    .load_i   (port_rd_i),
    .change_o (port_chg)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[BIT_TMR] = pin_fall[0];
    hw_set[BIT_PCH] = port_chg;
    hw_set[BIT_EXT] = pin_fall[1];
  end

  irq_flag_bank u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (hw_set),
    .wr_en_i   (flag_wr_i),
    .wr_data_i (wdata_i[NSRC-1:0]),
    .flag_o    (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (disi_i) gie_q <= 1'b0;
    else if (eni_i)  gie_q <= 1'b1;
  end

  assign live      = masked(flags, mask_q);
  assign flag_rd_o = {{PAD{1'b0}}, live};
  assign mask_rd_o = {{PAD{1'b0}}, mask_q};
  assign irq_o     = gie_q & (|live);

  // R7
  rd_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_o & ~mask_rd_o) == '0);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_rd_o != '0));

  // R10
  disi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disi_i |=> !irq_o);
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_n = 1'b1, ext_n = 1'b1;
  logic [7:0] port = 8'h00;
  logic       port_rd = 0, flag_wr = 0, mask_wr = 0, eni = 0, disi = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] flag_rd, mask_rd;
  logic       irq;

  int total = 0, bad = 0;

  // bench model state
  logic [2:0] m_flag = 0, m_mask = 0;
  logic       m_gie = 0, m_tp = 1, m_ep = 1;
  logic [7:0] m_ref = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tmr_n_i(tmr_n), .ext_n_i(ext_n),
    .port_i(port), .port_rd_i(port_rd), .flag_wr_i(flag_wr),
    .mask_wr_i(mask_wr), .wdata_i(wdata), .eni_i(eni), .disi_i(disi),
    .flag_rd_o(flag_rd), .mask_rd_o(mask_rd), .irq_o(irq)
  );

  function automatic logic [7:0] exp_frd(logic [2:0] f, logic [2:0] m);
    return {5'b0, f & m};
  endfunction

  function automatic logic exp_irq(logic g, logic [2:0] f, logic [2:0] m);
    return g && ((f & m) != 3'b0);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_model();
    check("R7", flag_rd, exp_frd(m_flag, m_mask));
    check("R8", mask_rd, {5'b0, m_mask});
    check("R9", {7'b0, irq}, {7'b0, exp_irq(m_gie, m_flag, m_mask)});
  endtask

  // Inputs are already driven; advance the model across one edge.
  task automatic step();
    logic [2:0] set;
    set    = {m_ep & ~ext_n, port != m_ref, m_tp & ~tmr_n};
    m_flag = (flag_wr ? (m_flag & wdata[2:0]) : m_flag) | set;
    if (mask_wr) m_mask = wdata[2:0];
    if (disi) m_gie = 0; else if (eni) m_gie = 1;
    if (port_rd) m_ref = port;
    m_tp = tmr_n;
    m_ep = ext_n;
    @(posedge clk);
    @(negedge clk);
    port_rd = 0; flag_wr = 0; mask_wr = 0; eni = 0; disi = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1a2b;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", flag_rd, 8'h00);
    check("R1", mask_rd, 8'h00);
    check("R1", {7'b0, irq}, 8'h00);

    // R8 mask write, upper bits ignored
    wdata = 8'hff; mask_wr = 1; step();
    check("R8", mask_rd, 8'h07);

    // R2 timer falling edge sets bit 0, rising does not
    tmr_n = 0; step();
    check("R2", flag_rd, 8'h01);
    flag_wr = 1; wdata = 8'hfe; step();
    check("R5", flag_rd, 8'h00);
    tmr_n = 1; step();
    check("R2", flag_rd, 8'h00);

    // R3 external falling edge sets bit 2
    ext_n = 0; step();
    check("R3", flag_rd, 8'h04);
    step();
    // R5 writing 1 keeps, writing 0 clears
    flag_wr = 1; wdata = 8'hff; step();
    check("R5", flag_rd, 8'h04);
    flag_wr = 1; wdata = 8'hfb; step();
    check("R5", flag_rd, 8'h00);
    ext_n = 1; step();

    // R4 port mismatch sets bit 1 until reference loaded
    port = 8'h5a; step();
    check("R4", flag_rd, 8'h02);
    port_rd = 1; step();
    flag_wr = 1; wdata = 8'h00; step();
    check("R4", flag_rd, 8'h00);

    // R6 set beats clear at the same edge
    tmr_n = 0; flag_wr = 1; wdata = 8'h00; step();
    check("R6", flag_rd, 8'h01);

    // R10 and R9
    eni = 1; step();
    check("R9", {7'b0, irq}, 8'h01);
    eni = 1; disi = 1; step();
    check("R10", {7'b0, irq}, 8'h00);
    eni = 1; step();
    mask_wr = 1; wdata = 8'h02; step();
    check("R9", {7'b0, irq}, 8'h00);
    tmr_n = 1; step();
    check_model();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      tmr_n   = $urandom_range(0, 1);
      ext_n   = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) port = 8'($urandom);
      port_rd = ($urandom_range(0, 3) == 0);
      flag_wr = ($urandom_range(0, 3) == 0);
      mask_wr = ($urandom_range(0, 7) == 0);
      wdata   = 8'($urandom);
      eni     = ($urandom_range(0, 5) == 0);
      disi    = ($urandom_range(0, 7) == 0);
      step();
      check_model();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule